// File: doc/BRIEF.md
# Half-Duplex Transmit Gap and Retry Controller

This block sits in front of an Ethernet MAC transmit serializer and decides the cycle on which a frame may begin. It holds off a pending frame until a programmable minimum interframe gap has passed. The gap is counted in bit-time ticks from the end of the previous transmission, or from the last cycle on which the medium showed carrier. Once the gap has passed, the block issues a one-cycle start grant.

While a frame is on the wire in half-duplex mode, the block watches the carrier-sense and collision inputs. A collision either sends the frame into a random backoff followed by a fresh attempt, or ends the frame with an excessive-collision result. A carrier that never appears, or that disappears mid-frame, ends the frame with the matching error unless carrier checking is switched off. In full-duplex mode, carrier and collision play no part in deferral or abort.

Each frame ends with a one-cycle done strobe and a status word. The configuration is captured when a request is accepted and is held for the rest of that frame.

Top module: `hdx_tx_gate`

## Requirements
- R1: The gap code `g` selects a minimum gap of 96 − 8·g bit times. With one tick per cycle, the grant `tx_start` rises exactly gap+1 clock edges after the edge that ended the previous transmission. The condition is that a request is pending and no carrier is present.
- R2: In half-duplex mode, gap codes 5, 6 and 7 are treated as code 4 (64 bit times). In full-duplex mode, all eight codes apply as encoded.
- R3: In half-duplex mode, a carrier seen while not transmitting restarts the gap count, so the grant comes gap+1 edges after the last edge that saw carrier. In full-duplex mode, carrier has no effect on the grant timing.
- R4: In half-duplex mode with carrier checking on, if no carrier appears within NOCRS_BITS ticks of the grant, the frame is aborted. The abort comes on the edge NOCRS_BITS+1 after the grant, and status bit 6 (no-carrier) is set.
- R5: In half-duplex mode with carrier checking on, a carrier that rises and then falls before `tx_end` aborts the frame on the edge after it falls, with status bit 5 (lost carrier) set.
- R6: With carrier checking off (`cfg_crs_ignore` = 1), carrier never aborts a frame and status bits 6 and 5 stay clear.
- R7: With `cfg_retry_off` = 1 in half-duplex mode, the first collision aborts the frame and ends it. The status shows bit 4 (excessive collision) set and a collision count of 1.
- R8: With retries enabled, each collision aborts the attempt and waits a random number of slots before retrying. The slot count is drawn from 0 to 2^k − 1, where k is the attempt number capped by the backoff-limit code (0→10, 1→8, 2→4, 3→1); a slot is SLOT_BITS ticks. The wait is also at least the gap. On the 16th collision the frame ends with bit 4 set and the count saturated at 15.
- R9: In full-duplex mode, collisions and missing carrier never abort a frame, and the frame ends at `tx_end` with a clear status.
- R10: `stat_done` is a one-cycle pulse per frame. `tx_status` bits [3:0] give the collision count of the frame, including on a frame that ends successfully after collisions.
- R11: The gap code, duplex, carrier-check, retry and backoff-limit inputs are sampled when a request is accepted. Changing them later has no effect on that frame.
- R12: After reset, `tx_start`, `tx_abort` and `stat_done` are low and `tx_status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_req | input | 1 | A frame is waiting to be sent |
| tx_end | input | 1 | Serializer has finished the current frame |
| bit_tick | input | 1 | One pulse per bit time |
| mii_crs | input | 1 | Carrier sense from the PHY |
| mii_col | input | 1 | Collision from the PHY |
| cfg_gap_code | input | 3 | Encoded minimum gap |
| cfg_full_duplex | input | 1 | 1 = full duplex |
| cfg_crs_ignore | input | 1 | 1 = no carrier errors in half duplex |
| cfg_retry_off | input | 1 | 1 = single attempt only |
| cfg_backoff_lim | input | 2 | Cap on the backoff exponent |
| tx_start | output | 1 | One-cycle grant to begin a transmission |
| tx_abort | output | 1 | One-cycle strobe to stop the current transmission |
| stat_done | output | 1 | One-cycle end-of-frame strobe |
| tx_status | output | 7 | {no-carrier, lost carrier, excessive collision, count[3:0]} |

## Verification
On every cycle, the assertions check the following:
- no grant is given before the held gap, and no half-duplex grant before 64 bit times;
- an abort only ever ends a transmission, and never occurs in full duplex;
- the done strobe lasts one cycle;
- the status word agrees with the retry and carrier-check settings of the frame.

Some behaviour can only be shown by the bench's scenarios. This covers the exact number of edges from end of frame, or from carrier release, to the grant, across every gap code in both duplex modes. It also covers the no-carrier window length, the bounds on each randomized backoff wait, and the sixteen-attempt limit.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GAP     = 2'd1,
    ST_XMIT    = 2'd2,
    ST_BACKOFF = 2'd3
  } tx_state_e;

  typedef struct packed {
    logic       no_carrier;
    logic       lost_carrier;
    logic       excess_col;
    logic [3:0] col_count;
  } tx_stat_t;

  // Gap in bit times: 96 minus 8 per code step, floored at code 4 in half duplex.
  function automatic logic [6:0] gap_bits(input logic [2:0] code, input logic full_dx);
    logic [2:0] c;
    c = (!full_dx && code > 3'd4) ? 3'd4 : code;
    return 7'd96 - {1'b0, c, 3'b000};
  endfunction

  // Backoff exponent: attempt number limited by the configured cap.
  function automatic logic [3:0] backoff_exp(input logic [1:0] lim, input logic [4:0] attempt);
    logic [3:0] cap;
    case (lim)
      2'd0:    cap = 4'd10;
      2'd1:    cap = 4'd8;
      2'd2:    cap = 4'd4;
      default: cap = 4'd1;
    endcase
    return (attempt > {1'b0, cap}) ? cap : attempt[3:0];
  endfunction

endpackage

// File: rtl/hdx_gap_timer.sv
module hdx_gap_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] need,
  output logic [CNT_W-1:0] cnt,
  output logic             met
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clear)                 cnt_d = '0;
    else if (tick && cnt != SAT) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign met = (cnt >= need);
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
  parameter int SLOT_BITS = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [3:0] exp_k,
  output logic       busy
);
  localparam int             LFSR_W = 10;
  localparam logic [LFSR_W-1:0] TAPS = 10'h240;
  localparam int             BIT_W  = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [LFSR_W-1:0] slots_q, slots_d;
  logic [BIT_W-1:0]  bits_q, bits_d;
  logic [LFSR_W:0]   mask_w;

  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    mask_w = (11'd1 << exp_k) - 11'd1;
    slots_d = slots_q;
    bits_d  = bits_q;
    if (load) begin
      slots_d = lfsr_q & mask_w[LFSR_W-1:0];
      bits_d  = '0;
    end else if (tick && busy) begin
      if (bits_q == BIT_LAST) begin
        bits_d  = '0;
        slots_d = slots_q - 1'b1;
      end else begin
        bits_d = bits_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= 10'h001;
      slots_q <= '0;
      bits_q  <= '0;
    end else begin
      lfsr_q  <= lfsr_d;
      slots_q <= slots_d;
      bits_q  <= bits_d;
    end
  end

  assign busy = (slots_q != '0);
endmodule

// File: rtl/hdx_tx_gate.sv
module hdx_tx_gate
  import hdx_tx_pkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int NOCRS_BITS   = 64,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_req,
  input  logic       tx_end,
  input  logic       bit_tick,
  input  logic       mii_crs,
  input  logic       mii_col,
  input  logic [2:0] cfg_gap_code,
  input  logic       cfg_full_duplex,
  input  logic       cfg_crs_ignore,
  input  logic       cfg_retry_off,
  input  logic [1:0] cfg_backoff_lim,
  output logic       tx_start,
  output logic       tx_abort,
  output logic       stat_done,
  output logic [6:0] tx_status
);
  localparam int GAP_W = 7;
  localparam int ATT_W = 5;
  localparam int NC_W  = $clog2(NOCRS_BITS + 1);
  localparam logic [NC_W-1:0]  NC_LIMIT = NC_W'(NOCRS_BITS);
  localparam logic [ATT_W-1:0] ATT_MAX  = ATT_W'(MAX_ATTEMPTS);

  tx_state_e state_q, state_d;
  logic [2:0] hold_gap_q, hold_gap_d;
  logic       hold_fd_q, hold_fd_d;
  logic       hold_ign_q, hold_ign_d;
  logic       hold_rtoff_q, hold_rtoff_d;
  logic [1:0] hold_lim_q, hold_lim_d;
  logic       crs_seen_q, crs_seen_d;
  logic [NC_W-1:0]  nocrs_q, nocrs_d;
  logic [ATT_W-1:0] att_q, att_d;
  tx_stat_t   stat_q, stat_d;
  logic       start_q, start_d;
  logic       abort_q, abort_d;
  logic       done_q, done_d;

  logic             fd_eff, crs_eff, hd_live, gap_clear, gap_met, bo_load, bo_busy;
  logic [GAP_W-1:0] gap_need, gap_cnt;
  logic [ATT_W-1:0] att_next;
  logic [3:0]       bo_exp;

  assign fd_eff    = (state_q == ST_IDLE) ? cfg_full_duplex : hold_fd_q;
  assign crs_eff   = mii_crs && !fd_eff;
  assign hd_live   = !hold_fd_q;
  assign gap_clear = (state_q == ST_XMIT) || crs_eff;
  assign gap_need  = gap_bits(hold_gap_q, hold_fd_q);
  assign att_next  = att_q + 1'b1;
  assign bo_exp    = backoff_exp(hold_lim_q, att_next);

  hdx_gap_timer #(.CNT_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .clear(gap_clear),
    .need(gap_need), .cnt(gap_cnt), .met(gap_met)
  );

  hdx_backoff #(.SLOT_BITS(SLOT_BITS)) u_bo (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(bo_load),
    .exp_k(bo_exp), .busy(bo_busy)
  );

  always_comb begin
    state_d      = state_q;
    hold_gap_d   = hold_gap_q;
    hold_fd_d    = hold_fd_q;
    hold_ign_d   = hold_ign_q;
    hold_rtoff_d = hold_rtoff_q;
    hold_lim_d   = hold_lim_q;
    crs_seen_d   = crs_seen_q;
    nocrs_d      = nocrs_q;
    att_d        = att_q;
    stat_d       = stat_q;
    start_d      = 1'b0;
    abort_d      = 1'b0;
    done_d       = 1'b0;
    bo_load      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_req) begin
          state_d      = ST_GAP;
          hold_gap_d   = cfg_gap_code;
          hold_fd_d    = cfg_full_duplex;
          hold_ign_d   = cfg_crs_ignore;
          hold_rtoff_d = cfg_retry_off;
          hold_lim_d   = cfg_backoff_lim;
          att_d        = '0;
          stat_d       = '0;
        end
      end
      ST_GAP: begin
        if (gap_met && !crs_eff) begin
          state_d    = ST_XMIT;
          start_d    = 1'b1;
          crs_seen_d = 1'b0;
          nocrs_d    = '0;
        end
      end
      ST_XMIT: begin
        if (mii_crs) crs_seen_d = 1'b1;
        if (bit_tick && !crs_seen_q && nocrs_q != NC_LIMIT) nocrs_d = nocrs_q + 1'b1;
        if (hd_live && mii_col) begin
          abort_d          = 1'b1;
          att_d            = att_next;
          stat_d.col_count = (att_next > 5'd15) ? 4'd15 : att_next[3:0];
          if (hold_rtoff_q || att_next >= ATT_MAX) begin
            stat_d.excess_col = 1'b1;
            done_d            = 1'b1;
            state_d           = ST_IDLE;
          end else begin
            bo_load = 1'b1;
            state_d = ST_BACKOFF;
          end
        end else if (tx_end) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (hd_live && !hold_ign_q && !mii_crs) begin
          if (crs_seen_q) begin
            stat_d.lost_carrier = 1'b1;
            abort_d = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (nocrs_q >= NC_LIMIT) begin
            stat_d.no_carrier = 1'b1;
            abort_d = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_BACKOFF: begin
        if (!bo_busy) state_d = ST_GAP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      hold_gap_q   <= '0;
      hold_fd_q    <= 1'b0;
      hold_ign_q   <= 1'b0;
      hold_rtoff_q <= 1'b0;
      hold_lim_q   <= '0;
      crs_seen_q   <= 1'b0;
      nocrs_q      <= '0;
      att_q        <= '0;
      stat_q       <= '0;
      start_q      <= 1'b0;
      abort_q      <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      hold_gap_q   <= hold_gap_d;
      hold_fd_q    <= hold_fd_d;
      hold_ign_q   <= hold_ign_d;
      hold_rtoff_q <= hold_rtoff_d;
      hold_lim_q   <= hold_lim_d;
      crs_seen_q   <= crs_seen_d;
      nocrs_q      <= nocrs_d;
      att_q        <= att_d;
      stat_q       <= stat_d;
      start_q      <= start_d;
      abort_q      <= abort_d;
      done_q       <= done_d;
    end
  end

  assign tx_start  = start_q;
  assign tx_abort  = abort_q;
  assign stat_done = done_q;
  assign tx_status = stat_q;
endmodule

// File: rtl/hdx_tx_gate_chk.sv
module hdx_tx_gate_chk
  import hdx_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       tx_abort,
  input logic       stat_done,
  input logic [6:0] tx_status,
  input tx_state_e  state,
  input logic       hold_fd,
  input logic       hold_ign,
  input logic       hold_rtoff,
  input logic [6:0] gap_cnt,
  input logic [6:0] gap_need
);
  a_r1_gap_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(gap_cnt) >= $past(gap_need));

  a_r2_hd_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !hold_fd) |-> $past(gap_cnt) >= 7'd64);

  a_r9_fd_never_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !hold_fd);

  a_r4_abort_ends_xmit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> $past(state) == ST_XMIT);

  a_r6_ignore_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_done && hold_ign) |-> tx_status[6:5] == 2'b00);

  a_r7_single_try: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_done && hold_rtoff && tx_status[4]) |-> tx_status[3:0] == 4'd1);

  a_r8_full_tries: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_done && !hold_rtoff && tx_status[4]) |-> tx_status[3:0] == 4'd15);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done |=> !stat_done);
endmodule

bind hdx_tx_gate hdx_tx_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_abort(tx_abort),
  .stat_done(stat_done), .tx_status(tx_status), .state(state_q),
  .hold_fd(hold_fd_q), .hold_ign(hold_ign_q), .hold_rtoff(hold_rtoff_q),
  .gap_cnt(gap_cnt), .gap_need(gap_need)
);

// File: tb/test_hdx_tx_gate.sv
module test_hdx_tx_gate;
  localparam int SLOT = 8;

  logic clk, rst_n, frame_req, tx_end, bit_tick, mii_crs, mii_col;
  logic [2:0] cfg_gap_code;
  logic cfg_full_duplex, cfg_crs_ignore, cfg_retry_off;
  logic [1:0] cfg_backoff_lim;
  logic tx_start, tx_abort, stat_done;
  logic [6:0] tx_status;

  int n_checks = 0;
  int n_err = 0;

  hdx_tx_gate #(.SLOT_BITS(SLOT), .NOCRS_BITS(64), .MAX_ATTEMPTS(16)) i_hdx_tx_gate (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .tx_end(tx_end),
    .bit_tick(bit_tick), .mii_crs(mii_crs), .mii_col(mii_col),
    .cfg_gap_code(cfg_gap_code), .cfg_full_duplex(cfg_full_duplex),
    .cfg_crs_ignore(cfg_crs_ignore), .cfg_retry_off(cfg_retry_off),
    .cfg_backoff_lim(cfg_backoff_lim), .tx_start(tx_start), .tx_abort(tx_abort),
    .stat_done(stat_done), .tx_status(tx_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!tx_start && n < 3000);
  endtask

  function automatic int need_of(input int c, input logic fd);
    int cc;
    cc = (!fd && c > 4) ? 4 : c;
    return 96 - 8 * cc;
  endfunction

  // Ends the current frame with tx_end; optionally leaves a new request pending.
  task automatic end_frame(input logic next_req, input int exp_stat, input string req);
    @(negedge clk);
    tx_end = 1'b1;
    frame_req = next_req;
    @(posedge clk); #1;
    check(stat_done === 1'b1, req, int'(stat_done), 1);
    check(tx_status === 7'(exp_stat), req, int'(tx_status), exp_stat);
    @(negedge clk);
    tx_end = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int n;
    int k;
    int hi;
    int aborts;
    rst_n = 1'b0; frame_req = 1'b0; tx_end = 1'b0; bit_tick = 1'b1;
    mii_crs = 1'b0; mii_col = 1'b0; cfg_gap_code = 3'd0; cfg_full_duplex = 1'b0;
    cfg_crs_ignore = 1'b1; cfg_retry_off = 1'b1; cfg_backoff_lim = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R12 reset state
    check(tx_start === 1'b0 && tx_abort === 1'b0 && stat_done === 1'b0, "R12", int'({tx_start, tx_abort, stat_done}), 0);
    check(tx_status === 7'd0, "R12", int'(tx_status), 0);

    @(negedge clk); frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0;

    // R1 and R2: sweep every gap code in both duplex modes
    for (int fd = 0; fd < 2; fd++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        cfg_gap_code = 3'(c); cfg_full_duplex = 1'(fd);
        end_frame(1'b1, 0, "R10");
        wait_start(n);
        check(n == need_of(c, 1'(fd)) + 1, (fd == 0 && c > 4) ? "R2" : "R1", n, need_of(c, 1'(fd)) + 1);
        @(negedge clk); frame_req = 1'b0;
      end
    end

    // R11: change the configuration after acceptance
    @(negedge clk); cfg_gap_code = 3'd0; cfg_full_duplex = 1'b0;
    end_frame(1'b1, 0, "R10");
    @(posedge clk); #1;
    @(negedge clk); cfg_gap_code = 3'd7; cfg_full_duplex = 1'b1;
    wait_start(n);
    check(n == 96, "R11", n, 96);
    @(negedge clk); frame_req = 1'b0; cfg_gap_code = 3'd0; cfg_full_duplex = 1'b0;

    // R3: carrier during the gap, half then full duplex
    for (int fd = 0; fd < 2; fd++) begin
      @(negedge clk); cfg_full_duplex = 1'(fd);
      end_frame(1'b1, 0, "R10");
      mii_crs = 1'b1;
      repeat (20) @(posedge clk);
      #1;
      @(negedge clk); mii_crs = 1'b0;
      wait_start(n);
      check(n == (fd == 0 ? 97 : 77), "R3", n, fd == 0 ? 97 : 77);
      @(negedge clk); frame_req = 1'b0;
    end

    // R4: no carrier in half duplex with checking on
    @(negedge clk); cfg_full_duplex = 1'b0; cfg_crs_ignore = 1'b0;
    end_frame(1'b1, 0, "R10");
    wait_start(n);
    @(negedge clk); frame_req = 1'b0;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!tx_abort && n < 200);
    check(n == 65, "R4", n, 65);
    check(stat_done === 1'b1 && tx_status === 7'b100_0000, "R4", int'(tx_status), 64);
    @(posedge clk); #1;
    check(stat_done === 1'b0, "R10", int'(stat_done), 0);

    // R5: carrier rises then drops mid-frame
    @(negedge clk); frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0; mii_crs = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); mii_crs = 1'b0;
    @(posedge clk); #1;
    check(tx_abort === 1'b1 && stat_done === 1'b1, "R5", int'({tx_abort, stat_done}), 3);
    check(tx_status === 7'b010_0000, "R5", int'(tx_status), 32);

    // R6: carrier checking off
    @(negedge clk); cfg_crs_ignore = 1'b1; frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0;
    aborts = 0;
    for (int i = 0; i < 100; i++) begin
      if (i == 10) mii_crs = 1'b1;
      if (i == 15) mii_crs = 1'b0;
      @(posedge clk); #1;
      if (tx_abort) aborts++;
      @(negedge clk);
    end
    check(aborts == 0, "R6", aborts, 0);
    end_frame(1'b0, 0, "R6");

    // R7: retry disabled
    @(negedge clk); cfg_retry_off = 1'b1; frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0; mii_col = 1'b1;
    @(posedge clk); #1;
    check(tx_abort === 1'b1 && stat_done === 1'b1, "R7", int'({tx_abort, stat_done}), 3);
    check(tx_status === 7'b001_0001, "R7", int'(tx_status), 17);
    @(negedge clk); mii_col = 1'b0;

    // R8: sixteen attempts with backoff limit code 2 (cap 4)
    @(negedge clk); cfg_retry_off = 1'b0; cfg_backoff_lim = 2'd2; frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0;
    for (int a = 1; a <= 16; a++) begin
      @(negedge clk); mii_col = 1'b1;
      @(posedge clk); #1;
      check(tx_abort === 1'b1, "R8", int'(tx_abort), 1);
      if (a < 16) begin
        check(stat_done === 1'b0, "R8", int'(stat_done), 0);
        @(negedge clk); mii_col = 1'b0;
        wait_start(n);
        k = (a > 4) ? 4 : a;
        hi = SLOT * ((1 << k) - 1) + 2;
        if (hi < 97) hi = 97;
        check(n >= 97 && n <= hi, "R8", n, hi);
      end else begin
        check(stat_done === 1'b1 && tx_status === 7'b001_1111, "R8", int'(tx_status), 31);
        @(negedge clk); mii_col = 1'b0;
      end
    end

    // R10: success after three collisions reports the count
    @(negedge clk); frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0;
    for (int a = 0; a < 3; a++) begin
      @(negedge clk); mii_col = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); mii_col = 1'b0;
      wait_start(n);
    end
    end_frame(1'b0, 3, "R10");

    // R9: full duplex ignores collision and missing carrier
    @(negedge clk); cfg_full_duplex = 1'b1; cfg_crs_ignore = 1'b0; frame_req = 1'b1;
    wait_start(n);
    @(negedge clk); frame_req = 1'b0;
    aborts = 0;
    for (int i = 0; i < 100; i++) begin
      mii_col = (i == 5);
      @(posedge clk); #1;
      if (tx_abort) aborts++;
      @(negedge clk);
    end
    mii_col = 1'b0;
    check(aborts == 0, "R9", aborts, 0);
    end_frame(1'b0, 0, "R9");

    summary();
  end
endmodule